// File: doc/BRIEF.md
# Event Capture Timer with PWM Mode

This block is a timestamp peripheral on a simple word-addressed register bus. A free-running counter is sampled into one of four slot registers each time a rising edge appears on the `cap_in` pin. The slots are filled in turn by an event pointer. Any event can clear the counter as it is captured, so the slots hold intervals between edges instead of absolute times. Capturing can run continuously, with the pointer wrapping after a chosen stop event, or stop after that event until software rearms it. Each event sets a flag, and enabled flags drive an interrupt line.

In PWM mode the same counter and slot registers make a single-output pulse-width modulator. Slot 3 holds the period shadow and slot 4 holds the compare shadow. Both are copied into active registers when the counter wraps. A period of N cycles is programmed by writing N-1.

Top module: `evcap_timer`

## Requirements
- R1: After reset every register reads 0 (counter word 0, slots words 1 to 4, control word 5, enable word 6, flags word 7), and `irq` and `pwm_out` are low.
- R2: The counter (word 0) rises by one per clock while control bit 8 is 1 and holds while it is 0. It wraps modulo 2^CNT_W. A bus write to word 0 loads it and takes priority over every other update.
- R3: A rising edge on `cap_in` passes SYNC_STAGES synchronizer flops and one edge flop. On the (SYNC_STAGES+1)-th rising clock edge after `cap_in` is first seen high, the count held just before that edge is stored. Capture happens only while control bit 4 is 1 and control bit 9 is 0.
- R4: Successive events fill slot 1 to slot 4 (words 1 to 4) in that order.
- R5: Control bit k (k = 0..3) clears the counter on the same edge that captures event k+1, so the next slot holds the interval.
- R6: With control bit 5 = 1 (one-shot), capture stops after the event numbered control[7:6]+1. Later edges change no slot and no flag.
- R7: Writing word 5 with bit 10 = 1 returns the pointer to event 1 and re-enables capture. Bit 10 always reads back 0.
- R8: With control bit 5 = 0, the pointer wraps to event 1 after the stop event and capture continues into slot 1.
- R9: Event n sets flag bit n (word 7, bits 1 to 4). Flag bit 0 is set by any event whose enable bit n (word 6) is 1. Writing word 8 clears each flag bit written as 1 and leaves bits written as 0 unchanged.
- R10: `irq` is high exactly when, for some n from 1 to 4, flag bit n and enable bit n are both 1.
- R11: With control bits 9 and 8 both 1, the counter returns to 0 on the clock after it reaches the active period (count >= period). At that same edge, slot 3 and slot 4 are copied into the active period and compare registers, so the period is slot3+1 cycles.
- R12: In PWM mode `pwm_out` is high, one clock later, while the count is below the active compare. A compare of 0 keeps it low, and a compare above the period keeps it high. Outside PWM mode it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when 1, read when 0 |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data (combinational from address) |
| cap_in | input | 1 | Asynchronous capture input |
| pwm_out | output | 1 | PWM output |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with CNT_W = 16 and SYNC_STAGES = 2. The narrow counter lets a preload of 0xFFFE show the modulo wrap within a few cycles. The fixed two-stage synchronizer gives a capture edge exactly three clocks after the pin rises, so slot values can be predicted to the cycle. PWM periods of 5 and 10 cycles keep measurement windows to whole periods, which makes high-cycle counts exact for zero, middle and saturating compare values.

// File: rtl/evcap_pkg.sv
package evcap_pkg;
  localparam int NUM_SLOTS = 4;
  localparam int PTR_W     = $clog2(NUM_SLOTS);
  localparam int ADDR_W    = 4;
  localparam int CTRL_W    = 10;
  localparam int REARM_BIT = 10;
  localparam int PRD_SLOT  = 2;
  localparam int CMP_SLOT  = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_COUNT = 4'd0,
    A_SLOT0 = 4'd1,
    A_CTRL  = 4'd5,
    A_IEN   = 4'd6,
    A_FLAGS = 4'd7,
    A_FCLR  = 4'd8
  } reg_addr_e;

  // first member is the most significant field
  typedef struct packed {
    logic                 pwm_mode;   // bit 9
    logic                 run;        // bit 8
    logic [PTR_W-1:0]     stop_idx;   // bits 7:6
    logic                 single;     // bit 5
    logic                 load_en;    // bit 4
    logic [NUM_SLOTS-1:0] rst_after;  // bits 3:0
  } ctrl_t;
endpackage

// File: rtl/evcap_rst_sync.sv
module evcap_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb stage_d = {stage_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/evcap_edge_det.sv
module evcap_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [SYNC_STAGES:0] sh_q;
  logic [SYNC_STAGES:0] sh_d;

  always_comb sh_d = {sh_q[SYNC_STAGES-1:0], din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
endmodule

// File: rtl/evcap_counter.sv
module evcap_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt_q
);
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load | clr | run;
    if (load)     cnt_d = load_val;
    else if (clr) cnt_d = '0;
    else          cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/evcap_seq.sv
module evcap_seq
  import evcap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  input  logic             cap_allow,
  input  logic             single,
  input  logic [PTR_W-1:0] stop_idx,
  input  logic             rearm,
  output logic             evt_fire,
  output logic [PTR_W-1:0] ptr_q,
  output logic             armed_q
);
  logic [PTR_W-1:0] ptr_d;
  logic             armed_d;
  logic             seq_en;

  assign evt_fire = rise & cap_allow & armed_q;

  always_comb begin
    ptr_d   = ptr_q;
    armed_d = armed_q;
    seq_en  = rearm | evt_fire;
    if (rearm) begin
      ptr_d   = '0;
      armed_d = 1'b1;
    end else if (evt_fire) begin
      if (ptr_q == stop_idx) begin
        ptr_d = '0;
        if (single) armed_d = 1'b0;
      end else begin
        ptr_d = ptr_q + PTR_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      armed_q <= 1'b1;
    end else if (seq_en) begin
      ptr_q   <= ptr_d;
      armed_q <= armed_d;
    end
  end
endmodule

// File: rtl/evcap_pwm.sv
module evcap_pwm #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwm_mode,
  input  logic             run,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] prd_shadow,
  input  logic [CNT_W-1:0] cmp_shadow,
  output logic             wrap,
  output logic             pwm_out
);
  logic [CNT_W-1:0] prd_q;
  logic [CNT_W-1:0] cmp_q;
  logic             out_q;
  logic             out_d;

  always_comb begin
    wrap  = pwm_mode & run & (cnt >= prd_q);
    out_d = pwm_mode & (cnt < cmp_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prd_q <= '0;
      cmp_q <= '0;
    end else if (wrap) begin
      prd_q <= prd_shadow;
      cmp_q <= cmp_shadow;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= out_d;
  end

  assign pwm_out = out_q;
endmodule

// File: rtl/evcap_timer.sv
module evcap_timer
  import evcap_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              cap_in,
  output logic              pwm_out,
  output logic              irq
);
  logic rst_n_sync;
  logic wr_en;
  logic cnt_load, ctrl_wr, ien_wr, fclr_wr, rearm;
  logic [NUM_SLOTS-1:0] slot_wr;

  ctrl_t ctrl_q, ctrl_d;
  logic [NUM_SLOTS:1] ien_q;
  logic [NUM_SLOTS:0] flag_q, flag_d, flag_set, flag_clr;
  logic               flag_en;
  logic [NUM_SLOTS-1:0][CNT_W-1:0] slot_q, slot_d;
  logic [NUM_SLOTS-1:0]            slot_en;

  logic             cap_rise, cap_allow, evt_fire, armed;
  logic [PTR_W-1:0] ptr;
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_clr, wrap, run, pwm_mode;

  evcap_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  // register decode
  assign wr_en = bus_sel & bus_we;

  always_comb begin
    cnt_load = 1'b0;
    ctrl_wr  = 1'b0;
    ien_wr   = 1'b0;
    fclr_wr  = 1'b0;
    slot_wr  = '0;
    if (wr_en) begin
      if (bus_addr == A_COUNT) cnt_load = 1'b1;
      if (bus_addr == A_CTRL)  ctrl_wr  = 1'b1;
      if (bus_addr == A_IEN)   ien_wr   = 1'b1;
      if (bus_addr == A_FCLR)  fclr_wr  = 1'b1;
      for (int i = 0; i < NUM_SLOTS; i++) begin
        if (bus_addr == ADDR_W'(int'(A_SLOT0) + i)) slot_wr[i] = 1'b1;
      end
    end
    rearm = ctrl_wr & bus_wdata[REARM_BIT];
  end

  // control and enable registers
  assign ctrl_d   = ctrl_t'(bus_wdata[CTRL_W-1:0]);
  assign run      = ctrl_q.run;
  assign pwm_mode = ctrl_q.pwm_mode;

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync)  ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= ctrl_d;
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) ien_q <= '0;
    else if (ien_wr) ien_q <= bus_wdata[NUM_SLOTS:1];
  end

  // capture path
  evcap_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .din   (cap_in),
    .rise  (cap_rise)
  );

  assign cap_allow = ctrl_q.load_en & ~ctrl_q.pwm_mode;

  evcap_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .rise      (cap_rise),
    .cap_allow (cap_allow),
    .single    (ctrl_q.single),
    .stop_idx  (ctrl_q.stop_idx),
    .rearm     (rearm),
    .evt_fire  (evt_fire),
    .ptr_q     (ptr),
    .armed_q   (armed)
  );

  // counter
  assign cnt_clr = (evt_fire & ctrl_q.rst_after[ptr]) | wrap;

  evcap_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .run      (run),
    .load     (cnt_load),
    .load_val (bus_wdata[CNT_W-1:0]),
    .clr      (cnt_clr),
    .cnt_q    (cnt_q)
  );

  // slot registers: bus write wins over a capture in the same cycle
  always_comb begin
    for (int i = 0; i < NUM_SLOTS; i++) begin
      slot_en[i] = slot_wr[i] | (evt_fire & (ptr == PTR_W'(i)));
      slot_d[i]  = slot_wr[i] ? bus_wdata[CNT_W-1:0] : cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      slot_q <= '0;
    end else begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        if (slot_en[i]) slot_q[i] <= slot_d[i];
      end
    end
  end

  // PWM
  evcap_pwm #(.CNT_W(CNT_W)) u_pwm (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .pwm_mode   (pwm_mode),
    .run        (run),
    .cnt        (cnt_q),
    .prd_shadow (slot_q[PRD_SLOT]),
    .cmp_shadow (slot_q[CMP_SLOT]),
    .wrap       (wrap),
    .pwm_out    (pwm_out)
  );

  // flags: a set in the same cycle as a clear wins
  always_comb begin
    flag_set = '0;
    if (evt_fire) begin
      flag_set[int'(ptr) + 1] = 1'b1;
      if (ien_q[int'(ptr) + 1]) flag_set[0] = 1'b1;
    end
    flag_clr = fclr_wr ? bus_wdata[NUM_SLOTS:0] : '0;
    flag_d   = (flag_q & ~flag_clr) | flag_set;
    flag_en  = evt_fire | fclr_wr;
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync)  flag_q <= '0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign irq = |(flag_q[NUM_SLOTS:1] & ien_q);

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_COUNT) bus_rdata = DATA_W'(cnt_q);
    if (bus_addr == A_CTRL)  bus_rdata = DATA_W'(ctrl_q);
    if (bus_addr == A_IEN)   bus_rdata = DATA_W'({ien_q, 1'b0});
    if (bus_addr == A_FLAGS) bus_rdata = DATA_W'(flag_q);
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (bus_addr == ADDR_W'(int'(A_SLOT0) + i)) bus_rdata = DATA_W'(slot_q[i]);
    end
  end
endmodule

// File: rtl/evcap_timer_chk.sv
module evcap_timer_chk
  import evcap_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic [CNT_W-1:0]   cnt_q,
  input logic               run,
  input logic               pwm_mode,
  input logic               cnt_load,
  input logic               cnt_clr,
  input logic               wrap,
  input logic [PTR_W-1:0]   ptr,
  input logic               armed,
  input logic               rearm,
  input logic               evt_fire,
  input logic [NUM_SLOTS:0] flag_q,
  input logic               fclr_wr,
  input logic [NUM_SLOTS:0] fclr_bits,
  input logic               pwm_out,
  input logic               irq
);
  p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(run && !cnt_load && !cnt_clr) |-> cnt_q == $past(cnt_q) + CNT_W'(1));

  p_cnt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!run && !cnt_load && !cnt_clr) |-> cnt_q == $past(cnt_q));

  p_pwm_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wrap && !cnt_load) |-> cnt_q == '0);

  p_single_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!armed && !rearm) |-> ptr == $past(ptr));

  p_rearm_ptr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rearm) |-> (ptr == '0) && armed);

  p_pwm_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!pwm_mode) |-> !pwm_out);

  p_irq_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag_q[NUM_SLOTS:1] != '0));

  for (genvar k = 1; k <= NUM_SLOTS; k++) begin : g_clr
    p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(fclr_wr && fclr_bits[k] && !(evt_fire && ptr == PTR_W'(k - 1)))
      |-> !flag_q[k]);
  end
endmodule

bind evcap_timer evcap_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_sync),
  .cnt_q     (cnt_q),
  .run       (run),
  .pwm_mode  (pwm_mode),
  .cnt_load  (cnt_load),
  .cnt_clr   (cnt_clr),
  .wrap      (wrap),
  .ptr       (ptr),
  .armed     (armed),
  .rearm     (rearm),
  .evt_fire  (evt_fire),
  .flag_q    (flag_q),
  .fclr_wr   (fclr_wr),
  .fclr_bits (bus_wdata[evcap_pkg::NUM_SLOTS:0]),
  .pwm_out   (pwm_out),
  .irq       (irq)
);

// File: tb/evcap_timer_tb.sv
`timescale 1ns/1ps
module evcap_timer_tb;
  localparam int CNT_W = 16;
  localparam int SYNC  = 2;
  localparam logic [3:0] W_CNT = 4'd0, W_S1 = 4'd1, W_S2 = 4'd2, W_S3 = 4'd3,
                         W_S4 = 4'd4, W_CTRL = 4'd5, W_IEN = 4'd6,
                         W_FLG = 4'd7, W_FCLR = 4'd8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cap_in = 1'b0;
  logic        pwm_out, irq;

  int n_checks = 0, n_errors = 0;
  int cyc = 0;
  int z = 0;
  bit done = 0;

  typedef struct { logic [3:0] addr; logic [31:0] exp; string tag; } exp_t;
  exp_t sb_q[$];

  evcap_timer #(.CNT_W(CNT_W), .DATA_W(32), .SYNC_STAGES(SYNC)) u_dut (
    .clk, .rst_n, .bus_sel, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
    .cap_in, .pwm_out, .irq
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic expect_reg(input logic [3:0] a, input logic [31:0] e, input string tag);
    exp_t it;
    it.addr = a; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
  endtask

  // monitor side of the scoreboard
  task automatic drain();
    logic [31:0] d;
    while (sb_q.size() > 0) begin
      exp_t it;
      it = sb_q.pop_front();
      bus_read(it.addr, d);
      check(d == it.exp, it.tag, d, it.exp);
    end
  endtask

  // driver: one pulse on cap_in; slot < 0 means the edge must be ignored
  task automatic capture(input int slot, input bit delta, input int gap, output int val);
    int c, p;
    @(negedge clk);
    cap_in = 1'b1;
    c = cyc;
    p = c + SYNC + 1;
    val = (p - 1 - z) & 16'hFFFF;
    if (slot >= 0) expect_reg(4'(slot + 1), 32'(val), "R3/R4/R5 slot value");
    if (delta) z = p;
    repeat (4) @(negedge clk);
    cap_in = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic count_high(input int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out) h++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int w, v, h, mx;
    int s1_keep, s2_keep, s3_keep;
    int vals[5];

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 8; a++) expect_reg(4'(a), 32'h0, "R1 reset value");
    drain();
    check(irq == 1'b0, "R1 irq after reset", 32'(irq), 0);
    check(pwm_out == 1'b0, "R1 pwm_out after reset", 32'(pwm_out), 0);

    // R2 counting, wrap at 2^16, hold
    bus_write(W_CTRL, 32'h100);
    bus_write(W_CNT, 32'hFFFE);
    w = cyc;
    repeat (3) @(negedge clk);
    bus_read(W_CNT, d);
    check(d == ((32'hFFFE + 32'(cyc - w)) & 32'hFFFF), "R2 count and wrap", d,
          (32'hFFFE + 32'(cyc - w)) & 32'hFFFF);
    bus_write(W_CTRL, 32'h000);
    v = (32'hFFFE + (cyc - w)) & 32'hFFFF;
    repeat (5) @(negedge clk);
    expect_reg(W_CNT, 32'(v), "R2 hold when stopped");
    expect_reg(W_CNT, 32'(v), "R2 hold when stopped again");
    drain();

    // R3 R4 R5 delta capture, continuous, stop at event 4
    bus_write(W_CTRL, 32'h1DF);
    bus_write(W_CNT, 32'h0);
    z = cyc;
    capture(0, 1, 4, vals[0]);
    capture(1, 1, 9, vals[1]);
    capture(2, 1, 6, vals[2]);
    capture(3, 1, 13, vals[3]);
    expect_reg(W_FLG, 32'h1E, "R9 event flags without enables");
    drain();
    check(irq == 1'b0, "R10 irq low with enables off", 32'(irq), 0);
    s2_keep = vals[1];
    s3_keep = vals[2];

    // R8 wrap into slot 1
    capture(0, 1, 5, vals[4]);
    expect_reg(W_S2, 32'(s2_keep), "R8 slot 2 untouched after wrap");
    drain();

    // R9 selective clears
    bus_write(W_FCLR, 32'h06);
    expect_reg(W_FLG, 32'h18, "R9 clear bits written 1");
    drain();
    bus_write(W_FCLR, 32'h00);
    expect_reg(W_FLG, 32'h18, "R9 zero bits leave flags");
    drain();
    bus_write(W_FCLR, 32'h1F);
    expect_reg(W_FLG, 32'h00, "R9 clear all");
    drain();

    // R6 R7 one-shot stopping after event 2
    bus_write(W_CTRL, 32'h570);
    expect_reg(W_CTRL, 32'h170, "R7 rearm reads 0");
    drain();
    bus_write(W_IEN, 32'h04);
    bus_write(W_CNT, 32'h0);
    z = cyc;
    capture(0, 0, 5, vals[0]);
    capture(1, 0, 5, vals[1]);
    s1_keep = vals[0];
    s2_keep = vals[1];
    expect_reg(W_FLG, 32'h07, "R9 global flag from enabled event");
    drain();
    check(irq == 1'b1, "R10 irq high for enabled flag", 32'(irq), 1);
    bus_write(W_FCLR, 32'h1F);
    @(negedge clk);
    check(irq == 1'b0, "R10 irq drops after clear", 32'(irq), 0);
    capture(-1, 0, 5, v);
    expect_reg(W_S1, 32'(s1_keep), "R6 slot 1 unchanged after stop");
    expect_reg(W_S2, 32'(s2_keep), "R6 slot 2 unchanged after stop");
    expect_reg(W_S3, 32'(s3_keep), "R6 slot 3 unchanged after stop");
    expect_reg(W_FLG, 32'h00, "R6 no flag after stop");
    drain();
    bus_write(W_CTRL, 32'h570);
    capture(0, 0, 5, v);
    expect_reg(W_FLG, 32'h02, "R7 capture resumes at event 1");
    drain();
    check(irq == 1'b0, "R10 irq low for disabled flag", 32'(irq), 0);
    bus_write(W_FCLR, 32'h1F);

    // R11 R12 PWM, period 5
    bus_write(W_S3, 32'd4);
    bus_write(W_S4, 32'd2);
    bus_write(W_CTRL, 32'h310);
    bus_write(W_CNT, 32'h0);
    repeat (12) @(negedge clk);
    count_high(40, h);
    check(h == 16, "R12 duty 2 of 5", 32'(h), 16);
    mx = 0;
    for (int i = 0; i < 12; i++) begin
      bus_read(W_CNT, d);
      if (int'(d) > mx) mx = int'(d);
    end
    check(mx == 4, "R11 count peaks at period value", 32'(mx), 4);
    capture(-1, 0, 5, v);
    expect_reg(W_S3, 32'd4, "R3 no capture in PWM mode");
    expect_reg(W_FLG, 32'h0, "R3 no flag in PWM mode");
    drain();
    bus_write(W_S4, 32'd0);
    repeat (12) @(negedge clk);
    count_high(40, h);
    check(h == 0, "R12 compare 0 keeps low", 32'(h), 0);
    bus_write(W_S4, 32'd7);
    repeat (12) @(negedge clk);
    count_high(40, h);
    check(h == 40, "R12 compare above period keeps high", 32'(h), 40);
    bus_write(W_S3, 32'd9);
    bus_write(W_S4, 32'd3);
    repeat (20) @(negedge clk);
    count_high(40, h);
    check(h == 12, "R11 new period 10 with duty 3", 32'(h), 12);
    bus_write(W_CTRL, 32'h000);
    repeat (3) @(negedge clk);
    check(pwm_out == 1'b0, "R12 low outside PWM mode", 32'(pwm_out), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule